// File: doc/BRIEF.md
# Dual-Channel Linear CCD Clock Timing Generator

This block produces, from one master clock, all the digital drive waveforms for a two-output linear CCD sensor. Each of the two output channels gets a pair of complementary shift clocks, a last-stage clock, a reset gate pulse and a clamp pulse. One shared transfer pulse starts every line. The generator counts pixel periods across the line and can run the two channels in phase or offset by half a pixel period. It also selects a per-pixel clamp or a clamp held over a black-reference window at the start of the line.

Every width and count is a configuration input in master-clock cycles. The generator captures these inputs only at the start of each line, so a line in progress is never disturbed. A line consists of a quiet gap, the transfer pulse, a second quiet gap, and then `cfg_npix` pixel periods of `2*cfg_half` cycles. A one-cycle line-start strobe and a pixel-valid flag with an odd/even tag keep downstream sampling logic aligned. The configuration is taken to be valid: every width is at least 1, `cfg_half` is at least 2, and `cfg_rst_w + cfg_clp_w <= cfg_half`.

All outputs are registered, so each output shows the decode of the sequencer state one master-clock cycle earlier. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `ccd_clock_gen`

## Requirements
- R1: While `rst_n` is low, and for the two cycles after it rises, every output is at its idle level. Idle means `sh_a_o`=2'b11, and `sh_b_o`, `last_o`, `rstg_o`, `clmp_o`, `xfer_o`, `line_start_o`, `pix_valid_o` and `pix_odd_o` are all 0. The line then starts with the first quiet gap.
- R2: Each line is `cfg_gap` quiet cycles, then `cfg_tg_w` cycles with `xfer_o` high, then `cfg_gap` quiet cycles, then `cfg_npix` pixel periods of `2*cfg_half` cycles. Line-start strobes are therefore spaced `2*cfg_gap + cfg_tg_w + 2*cfg_npix*cfg_half` cycles apart.
- R3: During readout, channel 1 (bit 0) has `sh_a_o` high for the first `cfg_half` cycles of each pixel period and low for the rest. `sh_b_o` is its complement and `last_o` equals `sh_b_o`. Outside readout, `sh_a_o` is high and `sh_b_o` and `last_o` are low.
- R4: The reset gate pulse is high for `cfg_rst_w` cycles, starting in the cycle in which `sh_b_o` rises. It has returned low before the last-stage clock falls.
- R5: With `cfg_line_clamp`=0 (per-pixel clamp), `clmp_o` is high for `cfg_clp_w` cycles starting in the cycle after the reset pulse ends, once in every pixel period.
- R6: With `cfg_line_clamp`=1 (window clamp), `clmp_o` is high for the whole of readout pixels 0 to `cfg_ob-1` and low for every later pixel.
- R7: With `cfg_oop`=0, channel 2 (bit 1) matches channel 1 exactly. With `cfg_oop`=1, channel 2 shows during readout the channel-1 waveform shifted by `cfg_half` cycles, taken modulo the pixel period.
- R8: Reset gate and clamp stay low, and the shift clocks stay unchanged, through the quiet gaps and the transfer pulse.
- R9: `line_start_o` is high for one cycle, in the first cycle of readout. `pix_valid_o` is high for exactly the readout cycles. `pix_odd_o` is high in the first half of each pixel period.
- R10: The configuration inputs are captured in the first cycle of each line. Changes made during a line take effect only from the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_half | input | CNT_W | half pixel period, cycles |
| cfg_rst_w | input | CNT_W | reset gate pulse width, cycles |
| cfg_clp_w | input | CNT_W | per-pixel clamp width, cycles |
| cfg_tg_w | input | CNT_W | transfer pulse width, cycles |
| cfg_gap | input | CNT_W | quiet gap on each side of the transfer pulse, cycles |
| cfg_npix | input | PIX_W | pixel periods per line |
| cfg_ob | input | PIX_W | window-clamp length in pixels |
| cfg_line_clamp | input | 1 | 1 selects window clamp, 0 per-pixel clamp |
| cfg_oop | input | 1 | 1 offsets channel 2 by half a pixel period |
| xfer_o | output | 1 | shared transfer pulse |
| sh_a_o | output | 2 | first shift phase, one bit per channel |
| sh_b_o | output | 2 | second shift phase, one bit per channel |
| last_o | output | 2 | last-stage clock, one bit per channel |
| rstg_o | output | 2 | reset gate pulse, one bit per channel |
| clmp_o | output | 2 | clamp pulse, one bit per channel |
| line_start_o | output | 1 | strobe in the first readout cycle |
| pix_valid_o | output | 1 | high during readout |
| pix_odd_o | output | 1 | high in the odd-sample half of a pixel period |

## Verification
Four properties are checked on every cycle:
- reset gate and clamp are quiet while the transfer pulse is high;
- the shift clocks hold still around the transfer pulse;
- no last-stage clock falls in the cycle after a reset gate pulse;
- both channels match when the in-phase mode is latched.

Other per-cycle checks cover the sequencer counters staying in range, the line-start strobe lasting one cycle, and pixel-valid being low during the transfer pulse. The exact placement of pulses within a pixel period, the black-window clamp length, the line period, and the rule that configuration changes wait for the next line depend on chosen settings. Only the bench's scenarios show those, by comparing against its own model and by timing line-start strobes across configuration changes made mid-line.

// File: rtl/ccdg_pkg.sv
package ccdg_pkg;

  typedef enum logic [1:0] {
    ST_PRE  = 2'd0,
    ST_XFER = 2'd1,
    ST_POST = 2'd2,
    ST_READ = 2'd3
  } seq_st_t;

  typedef struct packed {
    logic sh_a;
    logic sh_b;
    logic last;
    logic rstg;
    logic clmp;
  } chan_wave_t;

  localparam chan_wave_t WAVE_IDLE = '{sh_a: 1'b1, sh_b: 1'b0, last: 1'b0, rstg: 1'b0, clmp: 1'b0};

endpackage

// File: rtl/ccdg_seq.sv
module ccdg_seq
  import ccdg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PIX_W = 14
) (
  input  logic             clk,
  input  logic             rst_l,
  input  logic [CNT_W-1:0] cfg_half,
  input  logic [CNT_W-1:0] cfg_rst_w,
  input  logic [CNT_W-1:0] cfg_clp_w,
  input  logic [CNT_W-1:0] cfg_tg_w,
  input  logic [CNT_W-1:0] cfg_gap,
  input  logic [PIX_W-1:0] cfg_npix,
  input  logic [PIX_W-1:0] cfg_ob,
  input  logic             cfg_line_clamp,
  input  logic             cfg_oop,
  output seq_st_t          st_o,
  output logic [CNT_W:0]   pos_o,
  output logic [PIX_W-1:0] pix_o,
  output logic [CNT_W-1:0] half_o,
  output logic [CNT_W-1:0] rst_w_o,
  output logic [CNT_W-1:0] clp_w_o,
  output logic [PIX_W-1:0] ob_o,
  output logic             line_clamp_o,
  output logic             oop_o
);

  localparam logic [CNT_W:0]   ONE_C = {{CNT_W{1'b0}}, 1'b1};
  localparam logic [PIX_W-1:0] ONE_P = {{(PIX_W-1){1'b0}}, 1'b1};

  seq_st_t          st_q, st_d;
  logic [CNT_W:0]   cnt_q, cnt_d;
  logic [PIX_W-1:0] pix_q, pix_d;

  logic [CNT_W-1:0] half_q, rst_w_q, clp_w_q, tg_w_q, gap_q;
  logic [PIX_W-1:0] npix_q, ob_q;
  logic             line_q, oop_q;

  logic             at_load;
  logic [CNT_W-1:0] eff_half, eff_tg_w, eff_gap;
  logic [PIX_W-1:0] eff_npix;
  logic [CNT_W:0]   per_last;

  // configuration is sampled only in the first cycle of a line
  assign at_load  = (st_q == ST_PRE) && (cnt_q == '0);
  assign eff_half = at_load ? cfg_half : half_q;
  assign eff_tg_w = at_load ? cfg_tg_w : tg_w_q;
  assign eff_gap  = at_load ? cfg_gap  : gap_q;
  assign eff_npix = at_load ? cfg_npix : npix_q;
  assign per_last = {eff_half, 1'b0} - ONE_C;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + ONE_C;
    pix_d = pix_q;
    case (st_q)
      ST_PRE: if (cnt_q == {1'b0, eff_gap} - ONE_C) begin
        st_d  = ST_XFER;
        cnt_d = '0;
      end
      ST_XFER: if (cnt_q == {1'b0, eff_tg_w} - ONE_C) begin
        st_d  = ST_POST;
        cnt_d = '0;
      end
      ST_POST: if (cnt_q == {1'b0, eff_gap} - ONE_C) begin
        st_d  = ST_READ;
        cnt_d = '0;
        pix_d = '0;
      end
      ST_READ: if (cnt_q == per_last) begin
        cnt_d = '0;
        if (pix_q == eff_npix - ONE_P) begin
          st_d  = ST_PRE;
          pix_d = '0;
        end else begin
          pix_d = pix_q + ONE_P;
        end
      end
      default: begin
        st_d  = ST_PRE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q    <= ST_PRE;
      cnt_q   <= '0;
      pix_q   <= '0;
      half_q  <= '0;
      rst_w_q <= '0;
      clp_w_q <= '0;
      tg_w_q  <= '0;
      gap_q   <= '0;
      npix_q  <= '0;
      ob_q    <= '0;
      line_q  <= 1'b0;
      oop_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pix_q <= pix_d;
      if (at_load) begin
        half_q  <= cfg_half;
        rst_w_q <= cfg_rst_w;
        clp_w_q <= cfg_clp_w;
        tg_w_q  <= cfg_tg_w;
        gap_q   <= cfg_gap;
        npix_q  <= cfg_npix;
        ob_q    <= cfg_ob;
        line_q  <= cfg_line_clamp;
        oop_q   <= cfg_oop;
      end
    end
  end

  assign st_o         = st_q;
  assign pos_o        = cnt_q;
  assign pix_o        = pix_q;
  assign half_o       = half_q;
  assign rst_w_o      = rst_w_q;
  assign clp_w_o      = clp_w_q;
  assign ob_o         = ob_q;
  assign line_clamp_o = line_q;
  assign oop_o        = oop_q;

  // R2: readout position and pixel index stay inside the latched line shape
  assert_pos_bound_R2: assert property (@(posedge clk) disable iff (!rst_l)
    (st_q == ST_READ) |-> (cnt_q <= {half_q, 1'b0} - ONE_C));
  assert_pix_bound_R2: assert property (@(posedge clk) disable iff (!rst_l)
    (st_q == ST_READ) |-> (pix_q < npix_q));

endmodule

// File: rtl/ccdg_chan.sv
module ccdg_chan
  import ccdg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PIX_W = 14
) (
  input  logic             reading,
  input  logic             offset,
  input  logic [CNT_W:0]   pos,
  input  logic [PIX_W-1:0] pix,
  input  logic [CNT_W-1:0] half,
  input  logic [CNT_W-1:0] rst_w,
  input  logic [CNT_W-1:0] clp_w,
  input  logic [PIX_W-1:0] ob,
  input  logic             line_clamp,
  output chan_wave_t       wave
);

  logic [CNT_W:0] h_ext, q, rst_end, clp_end;
  logic           late_half;

  assign h_ext   = {1'b0, half};
  assign q       = !offset ? pos : ((pos < h_ext) ? pos + h_ext : pos - h_ext);
  assign rst_end = h_ext + {1'b0, rst_w};
  assign clp_end = rst_end + {1'b0, clp_w};
  assign late_half = (q >= h_ext);

  always_comb begin
    wave = WAVE_IDLE;
    if (reading) begin
      wave.sh_a = !late_half;
      wave.sh_b = late_half;
      wave.last = late_half;
      wave.rstg = late_half && (q < rst_end);
      if (line_clamp) begin
        wave.clmp = (pix < ob);
      end else begin
        wave.clmp = (q >= rst_end) && (q < clp_end);
      end
    end
  end

endmodule

// File: rtl/ccd_clock_gen.sv
module ccd_clock_gen
  import ccdg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PIX_W = 14,
  parameter int N_CH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_half,
  input  logic [CNT_W-1:0] cfg_rst_w,
  input  logic [CNT_W-1:0] cfg_clp_w,
  input  logic [CNT_W-1:0] cfg_tg_w,
  input  logic [CNT_W-1:0] cfg_gap,
  input  logic [PIX_W-1:0] cfg_npix,
  input  logic [PIX_W-1:0] cfg_ob,
  input  logic             cfg_line_clamp,
  input  logic             cfg_oop,
  output logic             xfer_o,
  output logic [N_CH-1:0]  sh_a_o,
  output logic [N_CH-1:0]  sh_b_o,
  output logic [N_CH-1:0]  last_o,
  output logic [N_CH-1:0]  rstg_o,
  output logic [N_CH-1:0]  clmp_o,
  output logic             line_start_o,
  output logic             pix_valid_o,
  output logic             pix_odd_o
);

  logic [1:0] rsync_q;
  logic       rst_l;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_l = rsync_q[1];

  seq_st_t          st;
  logic [CNT_W:0]   pos;
  logic [PIX_W-1:0] pix, ob;
  logic [CNT_W-1:0] half, rst_w, clp_w;
  logic             line_clamp, oop, reading;

  ccdg_seq #(.CNT_W(CNT_W), .PIX_W(PIX_W)) u_seq (
    .clk(clk), .rst_l(rst_l),
    .cfg_half(cfg_half), .cfg_rst_w(cfg_rst_w), .cfg_clp_w(cfg_clp_w),
    .cfg_tg_w(cfg_tg_w), .cfg_gap(cfg_gap), .cfg_npix(cfg_npix), .cfg_ob(cfg_ob),
    .cfg_line_clamp(cfg_line_clamp), .cfg_oop(cfg_oop),
    .st_o(st), .pos_o(pos), .pix_o(pix),
    .half_o(half), .rst_w_o(rst_w), .clp_w_o(clp_w), .ob_o(ob),
    .line_clamp_o(line_clamp), .oop_o(oop)
  );

  assign reading = (st == ST_READ);

  chan_wave_t wave_d [N_CH];
  chan_wave_t wave_q [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic ch_offset;
    assign ch_offset = (g % 2 == 1) ? oop : 1'b0;

    ccdg_chan #(.CNT_W(CNT_W), .PIX_W(PIX_W)) u_chan (
      .reading(reading), .offset(ch_offset), .pos(pos), .pix(pix),
      .half(half), .rst_w(rst_w), .clp_w(clp_w), .ob(ob),
      .line_clamp(line_clamp), .wave(wave_d[g])
    );

    always_ff @(posedge clk or negedge rst_l) begin
      if (!rst_l) wave_q[g] <= WAVE_IDLE;
      else        wave_q[g] <= wave_d[g];
    end

    assign sh_a_o[g] = wave_q[g].sh_a;
    assign sh_b_o[g] = wave_q[g].sh_b;
    assign last_o[g] = wave_q[g].last;
    assign rstg_o[g] = wave_q[g].rstg;
    assign clmp_o[g] = wave_q[g].clmp;

    // R4: a last-stage fall never directly follows a reset gate cycle
    assert_last_after_rstg_R4: assert property (@(posedge clk) disable iff (!rst_l)
      $fell(last_o[g]) |-> !$past(rstg_o[g]));
  end

  logic xfer_d, ls_d, valid_d, odd_d;
  logic xfer_q, ls_q, valid_q, odd_q;

  assign xfer_d  = (st == ST_XFER);
  assign ls_d    = reading && (pos == '0) && (pix == '0);
  assign valid_d = reading;
  assign odd_d   = reading && (pos < {1'b0, half});

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      xfer_q  <= 1'b0;
      ls_q    <= 1'b0;
      valid_q <= 1'b0;
      odd_q   <= 1'b0;
    end else begin
      xfer_q  <= xfer_d;
      ls_q    <= ls_d;
      valid_q <= valid_d;
      odd_q   <= odd_d;
    end
  end

  assign xfer_o       = xfer_q;
  assign line_start_o = ls_q;
  assign pix_valid_o  = valid_q;
  assign pix_odd_o    = odd_q;

  // R8: reset gate and clamp are quiet during the transfer pulse
  assert_xfer_quiet_R8: assert property (@(posedge clk) disable iff (!rst_l)
    xfer_o |-> (rstg_o == '0) && (clmp_o == '0));
  // R8: shift clocks hold still while the transfer pulse is high and one cycle after
  assert_shift_still_R8: assert property (@(posedge clk) disable iff (!rst_l)
    (xfer_o || $past(xfer_o)) |-> ($stable(sh_a_o) && $stable(sh_b_o) && $stable(last_o)));
  // R7: with in-phase mode latched both channels show the same waveforms
  assert_in_phase_R7: assert property (@(posedge clk) disable iff (!rst_l)
    !oop |-> (sh_a_o[0] == sh_a_o[N_CH-1]) && (sh_b_o[0] == sh_b_o[N_CH-1]) &&
             (rstg_o[0] == rstg_o[N_CH-1]) && (clmp_o[0] == clmp_o[N_CH-1]));
  // R9: line-start strobe is a single cycle
  assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_l)
    line_start_o |=> !line_start_o);
  // R9: no pixel is flagged valid during the transfer pulse
  assert_no_valid_in_xfer_R9: assert property (@(posedge clk) disable iff (!rst_l)
    xfer_o |-> !pix_valid_o);

endmodule

// File: tb/sim_ccd_clock_gen.sv
module sim_ccd_clock_gen;

  localparam int CW = 12;
  localparam int PW = 14;

  logic clk = 1'b0;
  logic rst_n;
  logic [CW-1:0] cfg_half, cfg_rst_w, cfg_clp_w, cfg_tg_w, cfg_gap;
  logic [PW-1:0] cfg_npix, cfg_ob;
  logic cfg_line_clamp, cfg_oop;
  logic xfer_o, line_start_o, pix_valid_o, pix_odd_o;
  logic [1:0] sh_a_o, sh_b_o, last_o, rstg_o, clmp_o;

  always #5 clk = ~clk;

  ccd_clock_gen #(.CNT_W(CW), .PIX_W(PW), .N_CH(2)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_half(cfg_half), .cfg_rst_w(cfg_rst_w), .cfg_clp_w(cfg_clp_w),
    .cfg_tg_w(cfg_tg_w), .cfg_gap(cfg_gap), .cfg_npix(cfg_npix), .cfg_ob(cfg_ob),
    .cfg_line_clamp(cfg_line_clamp), .cfg_oop(cfg_oop),
    .xfer_o(xfer_o), .sh_a_o(sh_a_o), .sh_b_o(sh_b_o), .last_o(last_o),
    .rstg_o(rstg_o), .clmp_o(clmp_o), .line_start_o(line_start_o),
    .pix_valid_o(pix_valid_o), .pix_odd_o(pix_odd_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit started = 0, finished = 0;

  // behavioural reference model state
  int m_s1 = 0, m_s2 = 0, m_st = 0, m_cnt = 0, m_pix = 0;
  int c_half = 0, c_rw = 0, c_cw = 0, c_tg = 0, c_gap = 0, c_npix = 0, c_ob = 0;
  bit c_line = 0, c_oop = 0;
  bit [1:0] e_sha, e_shb, e_last, e_rs, e_cp;
  bit e_xfer, e_ls, e_val, e_odd, e_rd, e_line;

  task automatic chk(input bit act, input bit exp, input string tag, input string nm);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: got %0b expected %0b", tag, nm, cyc, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag, input string nm);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, nm, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int old_s2;
    cyc++;
    old_s2 = m_s2;
    if (!rst_n) begin m_s1 = 0; m_s2 = 0; end
    else begin m_s2 = m_s1; m_s1 = 1; end
    if (!rst_n || old_s2 == 0) begin
      e_sha = 2'b11; e_shb = 0; e_last = 0; e_rs = 0; e_cp = 0;
      e_xfer = 0; e_ls = 0; e_val = 0; e_odd = 0; e_rd = 0; e_line = 0;
      m_st = 0; m_cnt = 0; m_pix = 0;
      c_half = 0; c_rw = 0; c_cw = 0; c_tg = 0; c_gap = 0; c_npix = 0; c_ob = 0;
      c_line = 0; c_oop = 0;
    end else begin
      if (m_st == 0 && m_cnt == 0) begin
        c_half = int'(cfg_half); c_rw = int'(cfg_rw_i()); c_cw = int'(cfg_clp_w);
        c_tg = int'(cfg_tg_w); c_gap = int'(cfg_gap); c_npix = int'(cfg_npix);
        c_ob = int'(cfg_ob); c_line = cfg_line_clamp; c_oop = cfg_oop;
      end
      e_rd = (m_st == 3);
      e_line = c_line;
      for (int ch = 0; ch < 2; ch++) begin
        int q;
        q = (ch == 1 && c_oop) ? (m_cnt + c_half) % (2 * c_half) : m_cnt;
        e_sha[ch] = !e_rd || (q < c_half);
        e_shb[ch] = e_rd && (q >= c_half);
        e_last[ch] = e_shb[ch];
        e_rs[ch] = e_rd && (q >= c_half) && (q < c_half + c_rw);
        e_cp[ch] = e_rd && (c_line ? (m_pix < c_ob)
                                   : ((q >= c_half + c_rw) && (q < c_half + c_rw + c_cw)));
      end
      e_xfer = (m_st == 1);
      e_ls = e_rd && m_cnt == 0 && m_pix == 0;
      e_val = e_rd;
      e_odd = e_rd && (m_cnt < c_half);
      case (m_st)
        0: if (m_cnt == c_gap - 1) begin m_st = 1; m_cnt = 0; end else m_cnt++;
        1: if (m_cnt == c_tg - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
        2: if (m_cnt == c_gap - 1) begin m_st = 3; m_cnt = 0; m_pix = 0; end else m_cnt++;
        default: if (m_cnt == 2 * c_half - 1) begin
          m_cnt = 0;
          if (m_pix == c_npix - 1) begin m_st = 0; m_pix = 0; end else m_pix++;
        end else m_cnt++;
      endcase
    end
    started = 1;
    if (cyc > 20000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d: got hang expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [CW-1:0] cfg_rw_i();
    return cfg_rst_w;
  endfunction

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      chk(xfer_o, e_xfer, "R2", "xfer");
      for (int ch = 0; ch < 2; ch++) begin
        string t3, t4, t5;
        t3 = (ch == 1) ? "R7" : "R3";
        t4 = (ch == 1) ? "R7" : (e_rd ? "R4" : "R8");
        t5 = (ch == 1) ? "R7" : (!e_rd ? "R8" : (e_line ? "R6" : "R5"));
        chk(sh_a_o[ch], e_sha[ch], t3, "sh_a");
        chk(sh_b_o[ch], e_shb[ch], t3, "sh_b");
        chk(last_o[ch], e_last[ch], t3, "last");
        chk(rstg_o[ch], e_rs[ch], t4, "rstg");
        chk(clmp_o[ch], e_cp[ch], t5, "clmp");
      end
      chk(line_start_o, e_ls, "R9", "line_start");
      chk(pix_valid_o, e_val, "R9", "pix_valid");
      chk(pix_odd_o, e_odd, "R9", "pix_odd");
    end
  end

  task automatic set_cfg(input int h, input int rw, input int cw, input int tg, input int gap,
                         input int np, input int ob, input bit lc, input bit oop);
    cfg_half = CW'(h); cfg_rst_w = CW'(rw); cfg_clp_w = CW'(cw); cfg_tg_w = CW'(tg);
    cfg_gap = CW'(gap); cfg_npix = PW'(np); cfg_ob = PW'(ob);
    cfg_line_clamp = lc; cfg_oop = oop;
  endtask

  task automatic wait_ls(output int t);
    do @(negedge clk); while (!line_start_o);
    t = cyc;
  endtask

  task automatic chk_idle(input string nm);
    chk(xfer_o, 1'b0, "R1", {nm, " xfer"});
    chk(sh_a_o == 2'b11, 1'b1, "R1", {nm, " sh_a"});
    chk(|{sh_b_o, last_o, rstg_o, clmp_o}, 1'b0, "R1", {nm, " pulses"});
    chk(|{line_start_o, pix_valid_o, pix_odd_o}, 1'b0, "R1", {nm, " flags"});
  endtask

  initial begin
    int t0, t1, t2, t3;
    rst_n = 1'b0;
    set_cfg(4, 1, 2, 6, 3, 10, 3, 0, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk_idle("in reset");
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    chk_idle("sync release");

    // R2: line period with per-pixel clamp, in phase
    wait_ls(t0);
    wait_ls(t1);
    chk_int(t1 - t0, 2 * 3 + 6 + 10 * 8, "R2", "line period");

    // R10: change mid-line; current line keeps old shape
    @(posedge clk); #2 set_cfg(4, 1, 2, 6, 5, 6, 3, 0, 1);
    wait_ls(t2);
    chk_int(t2 - t1, 10 * 8 + 2 * 5 + 6, "R10", "period across change");
    wait_ls(t3);
    chk_int(t3 - t2, 6 * 8 + 2 * 5 + 6, "R2", "new line period");

    // R6: window clamp, out of phase
    @(posedge clk); #2 set_cfg(5, 2, 1, 4, 2, 7, 2, 1, 1);
    wait_ls(t0); wait_ls(t1);
    chk_int(t1 - t0, 2 * 2 + 4 + 7 * 10, "R6", "window clamp line period");

    // R6: window clamp covering all pixels, in phase
    @(posedge clk); #2 set_cfg(3, 2, 1, 2, 1, 4, 4, 1, 0);
    wait_ls(t0); wait_ls(t1);

    // R4 R5: tightest pixel period, out of phase
    @(posedge clk); #2 set_cfg(2, 1, 1, 1, 1, 1, 0, 0, 1);
    wait_ls(t0); wait_ls(t1); wait_ls(t2);
    chk_int(t2 - t1, 2 + 1 + 4, "R2", "minimum line period");

    // R1: reset during readout returns everything to idle
    @(posedge clk); #2 set_cfg(4, 2, 2, 3, 2, 5, 1, 0, 1);
    wait_ls(t0); wait_ls(t1);
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk_idle("mid-line reset");
    @(posedge clk); #2 rst_n = 1'b1;
    wait_ls(t0);
    chk_int(t0 - cyc, 0, "R1", "restart reaches readout");
    wait_ls(t1);
    chk_int(t1 - t0, 2 * 2 + 3 + 5 * 8, "R1", "period after restart");

    repeat (5) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule